// File: doc/BRIEF.md
# Serial Interface Status Flag Register

This block keeps the seven event flags of a serial port: two for the transmit side (data buffer empty, shifting finished) and five for the receive side (byte available, line idle, overrun, noise seen, bad stop bit). The transmitter and receiver report events as one-cycle set pulses. The processor sees the flags as one 8-bit status value, and each flag is also brought out on its own pin.

Software never writes a flag directly. A flag is cleared by a two-step acknowledge on the bus. The first step is a status read, which takes a snapshot of the flags and arms the clear. The second step is the next access to the data register. A data read clears the receive flags in the snapshot. A data write clears the transmit flags in the snapshot. A flag that rises after the snapshot is left set. A data write that is not armed clears nothing, and it raises a reject strobe so the transmitter can treat that byte as not validly queued.

The bus side uses one read strobe, one write strobe and one select bit. Select 0 addresses the status register and select 1 addresses the data register.

Top module: `ser_status_flags`

## Requirements
- R1: After reset the status value is 0xC0 (both transmit flags set, all receive flags clear) and `wr_reject` is low.
- R2: Status layout: bit 7 transmit-empty, bit 6 transmit-complete, bit 5 receive-full, bit 4 idle, bit 3 overrun, bit 2 noise, bit 1 framing error, and bit 0 always 0. A set pulse makes its flag read 1 from the cycle after the pulse.
- R3: A write with select 0 (status register) changes no flag.
- R4: A status read (read, select 0) arms a clear. The next data read (read, select 1) clears those of bits 5..1 that were 1 at the status read. The change shows in the cycle after the data read.
- R5: A receive flag that becomes set after the status read stays set through the arming data read.
- R6: A status read followed by a data write (write, select 1) clears those of bits 7..6 that were 1 at the status read. The change shows in the cycle after the write.
- R7: A data write with no armed status read clears no flag, and `wr_reject` is high in the same cycle as that write. `wr_reject` is low otherwise.
- R8: If a set pulse and a clear act on the same flag in the same cycle, the flag ends set.
- R9: The first data access (read or write) after a status read consumes the arm. A second data access with no new status read between clears nothing.
- R10: A data read never clears bits 7..6, and a data write never clears bits 5..1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_empty_set | input | 1 | Pulse: transmit buffer moved to shifter |
| tx_done_set | input | 1 | Pulse: transmitter went idle |
| rx_full_set | input | 1 | Pulse: received byte available |
| rx_idle_set | input | 1 | Pulse: idle line detected |
| rx_ovr_set | input | 1 | Pulse: receive overrun |
| rx_noise_set | input | 1 | Pulse: noise detected |
| rx_frame_set | input | 1 | Pulse: framing error |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel | input | 1 | Register select: 0 status, 1 data |
| stat_rdata | output | 8 | Status register read value |
| tx_empty | output | 1 | Transmit-empty flag |
| tx_done | output | 1 | Transmit-complete flag |
| rx_full | output | 1 | Receive-full flag |
| rx_idle | output | 1 | Idle flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_noise | output | 1 | Noise flag |
| rx_frame | output | 1 | Framing-error flag |
| wr_reject | output | 1 | Data write arrived with no armed status read |

## Verification
Flag changes from a set pulse or from an acknowledge access show in `stat_rdata` one clock edge after the pulse or strobe. `wr_reject` is combinational and is valid in the same cycle as the write strobe. The bench drives inputs just after the falling edge and compares every output against its behavioural model 1 ns later. After each rising edge it advances the model, so the registered results are compared one cycle after their cause and the reject strobe in the cycle it occurs.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int FLAG_N = 7;
    localparam int TX_N   = 2;
    localparam int REG_W  = FLAG_N + 1;

    typedef logic [FLAG_N-1:0] flag_vec_t;

    // Transmit flags occupy the upper TX_N flag positions.
    localparam flag_vec_t TX_SEL    = {{TX_N{1'b1}}, {(FLAG_N-TX_N){1'b0}}};
    localparam flag_vec_t RX_SEL    = ~TX_SEL;
    localparam flag_vec_t RST_FLAGS = TX_SEL;

    typedef struct packed {
        logic      armed;
        flag_vec_t snap;
    } arm_state_t;

    typedef struct packed {
        flag_vec_t flags;
    } bank_state_t;
endpackage

// File: rtl/ssr_bus_decode.sv
module ssr_bus_decode (
    input  logic bus_rd,
    input  logic bus_wr,
    input  logic bus_sel,
    output logic stat_rd,
    output logic data_rd,
    output logic data_wr
);
    // A write with select 0 decodes to nothing: the status register is read-only.
    always_comb begin
        stat_rd = bus_rd & ~bus_sel;
        data_rd = bus_rd &  bus_sel;
        data_wr = bus_wr &  bus_sel;
    end
endmodule

// File: rtl/ssr_ack_track.sv
module ssr_ack_track
    import ssr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stat_rd,
    input  logic      data_rd,
    input  logic      data_wr,
    input  flag_vec_t flags_q,
    output logic      armed_q,
    output flag_vec_t snap_q,
    output flag_vec_t clr_vec,
    output logic      wr_reject
);
    arm_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (st_q.armed && data_rd) clr_vec = clr_vec | (st_q.snap & RX_SEL);
        if (st_q.armed && data_wr) clr_vec = clr_vec | (st_q.snap & TX_SEL);
        if (stat_rd) begin
            st_d.armed = 1'b1;
            st_d.snap  = flags_q;
        end else if (data_rd || data_wr) begin
            st_d.armed = 1'b0;
        end
        wr_reject = data_wr & ~st_q.armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b0, snap: '0};
        else        st_q <= st_d;
    end

    assign armed_q = st_q.armed;
    assign snap_q  = st_q.snap;
endmodule

// File: rtl/ssr_flag_bank.sv
module ssr_flag_bank
    import ssr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_vec,
    input  flag_vec_t clr_vec,
    output flag_vec_t flags_q
);
    bank_state_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < FLAG_N; i++) begin
            // A set pulse overrides a clear in the same cycle.
            if (set_vec[i])      bk_d.flags[i] = 1'b1;
            else if (clr_vec[i]) bk_d.flags[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '{flags: RST_FLAGS};
        else        bk_q <= bk_d;
    end

    assign flags_q = bk_q.flags;
endmodule

// File: rtl/ser_status_flags.sv
module ser_status_flags
    import ssr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_empty_set,
    input  logic             tx_done_set,
    input  logic             rx_full_set,
    input  logic             rx_idle_set,
    input  logic             rx_ovr_set,
    input  logic             rx_noise_set,
    input  logic             rx_frame_set,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_sel,
    output logic [REG_W-1:0] stat_rdata,
    output logic             tx_empty,
    output logic             tx_done,
    output logic             rx_full,
    output logic             rx_idle,
    output logic             rx_ovr,
    output logic             rx_noise,
    output logic             rx_frame,
    output logic             wr_reject
);
    logic      stat_rd, data_rd, data_wr;
    logic      armed_q;
    flag_vec_t snap_q, clr_vec, flags_q, set_vec;

    assign set_vec = {tx_empty_set, tx_done_set, rx_full_set, rx_idle_set,
                      rx_ovr_set, rx_noise_set, rx_frame_set};

    ssr_bus_decode u_dec (
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .bus_sel (bus_sel),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .data_wr (data_wr)
    );

    ssr_ack_track u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd   (stat_rd),
        .data_rd   (data_rd),
        .data_wr   (data_wr),
        .flags_q   (flags_q),
        .armed_q   (armed_q),
        .snap_q    (snap_q),
        .clr_vec   (clr_vec),
        .wr_reject (wr_reject)
    );

    ssr_flag_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (flags_q)
    );

    assign stat_rdata = {flags_q, 1'b0};
    assign {tx_empty, tx_done, rx_full, rx_idle, rx_ovr, rx_noise, rx_frame} = flags_q;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
    import ssr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             bus_sel,
    input logic             rx_full_set,
    input logic [REG_W-1:0] stat_rdata,
    input logic             wr_reject,
    input logic             armed_q,
    input flag_vec_t        snap_q
);
    // R8: a receive-full pulse always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_set |=> stat_rdata[5]);

    // R4: receive-full falls only after an armed data read with it in the snapshot
    a_r4_rx_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_rdata[5]) |-> $past(bus_rd && bus_sel && armed_q && snap_q[4]));

    // R6: transmit-empty falls only after an armed data write with it in the snapshot
    a_r6_tx_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_rdata[7]) |-> $past(bus_wr && bus_sel && armed_q && snap_q[6]));

    // R3: with no data-register access, no bit can fall
    a_r3_no_fall_without_data: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && (bus_rd || bus_wr)) |=> (($past(stat_rdata) & ~stat_rdata) == '0));

    // R7: a rejected write clears no transmit flag
    a_r7_reject_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |=> !$fell(stat_rdata[7]) && !$fell(stat_rdata[6]));

    // R9: a data access without a status read leaves the clear disarmed
    a_r9_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && (bus_rd || bus_wr)) |=> !armed_q);

    // R2: bit 0 reads zero
    a_r2_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full_set) |-> (stat_rdata[0] == 1'b0));
endmodule

bind ser_status_flags ssr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_sel     (bus_sel),
    .rx_full_set (rx_full_set),
    .stat_rdata  (stat_rdata),
    .wr_reject   (wr_reject),
    .armed_q     (armed_q),
    .snap_q      (snap_q)
);

// File: tb/ser_status_flags_test.sv
`timescale 1ns/1ps
module ser_status_flags_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] sets = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0, bus_sel = 1'b0;
    logic [7:0] stat_rdata;
    logic tx_empty, tx_done, rx_full, rx_idle, rx_ovr, rx_noise, rx_frame, wr_reject;

    int vectors = 0;
    int errors  = 0;
    string tag = "R1";

    // behavioural model
    bit [7:0] m_flags;
    bit       m_armed;
    bit [7:0] m_snap;

    always #2 clk = ~clk;

    ser_status_flags uut (
        .clk(clk), .rst_n(rst_n),
        .tx_empty_set(sets[6]), .tx_done_set(sets[5]), .rx_full_set(sets[4]),
        .rx_idle_set(sets[3]), .rx_ovr_set(sets[2]), .rx_noise_set(sets[1]),
        .rx_frame_set(sets[0]),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .stat_rdata(stat_rdata),
        .tx_empty(tx_empty), .tx_done(tx_done), .rx_full(rx_full), .rx_idle(rx_idle),
        .rx_ovr(rx_ovr), .rx_noise(rx_noise), .rx_frame(rx_frame),
        .wr_reject(wr_reject)
    );

    task automatic compare();
        bit [7:0] pins;
        bit       exp_rej;
        pins    = {tx_empty, tx_done, rx_full, rx_idle, rx_ovr, rx_noise, rx_frame, 1'b0};
        exp_rej = bus_wr && bus_sel && !m_armed;
        vectors++;
        if (stat_rdata !== m_flags || pins !== m_flags || wr_reject !== exp_rej) begin
            errors++;
            $display("FAIL %s: stat=%02h pins=%02h rej=%0b expected stat=%02h rej=%0b",
                     tag, stat_rdata, pins, wr_reject, m_flags, exp_rej);
        end
    endtask

    task automatic model_step();
        bit [7:0] clr;
        clr = '0;
        if (m_armed && bus_rd && bus_sel) clr |= m_snap & 8'h3E;
        if (m_armed && bus_wr && bus_sel) clr |= m_snap & 8'hC0;
        if (bus_rd && !bus_sel) begin
            m_armed = 1'b1;
            m_snap  = m_flags;
        end else if (bus_sel && (bus_rd || bus_wr)) begin
            m_armed = 1'b0;
        end
        m_flags = (m_flags & ~clr) | {sets, 1'b0};
    endtask

    // one cycle: drive after falling edge, compare, advance at rising edge
    task automatic cyc(input bit [6:0] s, input bit rd, input bit wr, input bit sel);
        sets = s; bus_rd = rd; bus_wr = wr; bus_sel = sel;
        #1 compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(7'h00, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        m_flags = 8'hC0; m_armed = 1'b0; m_snap = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; idle(2);

        tag = "R2";  // each pulse alone, bit 0 stays 0
        for (int b = 0; b < 7; b++) begin
            cyc(7'(1 << b), 1'b0, 1'b0, 1'b0);
            idle(1);
        end

        tag = "R3";  // status write ignored, including between arm and data read
        cyc(7'h00, 1'b0, 1'b1, 1'b0);
        cyc(7'h00, 1'b1, 1'b0, 1'b0);
        cyc(7'h00, 1'b0, 1'b1, 1'b0);
        idle(1);

        tag = "R4";  // data read clears the snapshot receive flags
        cyc(7'h00, 1'b1, 1'b0, 1'b1);
        idle(1);

        tag = "R5";  // flag set between read and data read survives
        cyc(7'h1F, 1'b0, 1'b0, 1'b0);
        cyc(7'h00, 1'b1, 1'b0, 1'b0);   // status read: rx 1F set
        cyc(7'h00, 1'b1, 1'b0, 1'b1);   // clears them
        cyc(7'h04, 1'b0, 1'b0, 1'b0);
        cyc(7'h00, 1'b1, 1'b0, 1'b0);   // snapshot has only overrun... recompute
        cyc(7'h10, 1'b0, 1'b0, 1'b0);   // receive-full rises after snapshot
        cyc(7'h00, 1'b1, 1'b0, 1'b1);
        idle(1);

        tag = "R10";  // data read leaves tx, data write leaves rx
        cyc(7'h60, 1'b0, 1'b0, 1'b0);
        cyc(7'h00, 1'b1, 1'b0, 1'b0);
        cyc(7'h00, 1'b1, 1'b0, 1'b1);
        cyc(7'h1F, 1'b0, 1'b0, 1'b0);
        cyc(7'h00, 1'b1, 1'b0, 1'b0);
        idle(1);

        tag = "R6";  // data write clears tx flags in snapshot
        cyc(7'h00, 1'b0, 1'b1, 1'b1);
        idle(1);

        tag = "R7";  // unarmed write: reject, no clear
        cyc(7'h60, 1'b0, 1'b0, 1'b0);
        cyc(7'h00, 1'b0, 1'b1, 1'b1);
        cyc(7'h00, 1'b0, 1'b1, 1'b1);
        idle(1);

        tag = "R8";  // set and clear in same cycle
        cyc(7'h00, 1'b1, 1'b0, 1'b0);
        cyc(7'h10, 1'b1, 1'b0, 1'b1);
        cyc(7'h00, 1'b1, 1'b0, 1'b0);
        cyc(7'h40, 1'b0, 1'b1, 1'b1);
        idle(1);

        tag = "R9";  // second data access does not clear
        cyc(7'h7F, 1'b0, 1'b0, 1'b0);
        cyc(7'h00, 1'b1, 1'b0, 1'b0);
        cyc(7'h00, 1'b1, 1'b0, 1'b1);
        cyc(7'h1F, 1'b0, 1'b0, 1'b0);
        cyc(7'h00, 1'b1, 1'b0, 1'b1);
        cyc(7'h00, 1'b0, 1'b1, 1'b1);
        idle(1);

        tag = "R4";  // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            cyc(7'((r[6:0] & r[13:7]) & {7{r[14]}}), r[15] & r[16], r[17] & r[18], r[19]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule